// File: doc/BRIEF.md
# DDR4 MPR Readout Command Sequencer

This block produces the complete command stream needed to read the multipurpose register pages of one DDR4 rank. A single start pulse carries the target rank, the MPR page, the read format and the number of reads. The sequencer then emits, in a fixed order, a precharge-all, a mode-register-3 write that switches MPR mode on, the requested run of plain reads, and a second mode-register-3 write that switches MPR mode off.

Each command goes to a downstream executor over a valid/ready handshake. A command is a code, a rank, a mode-register select, an address and an idle count, and the executor waits for the idle count before it runs the next command. The idle counts encode the DDR4 spacing rules. The precharge uses tRP. Each mode write uses the larger of tMOD and tMRD. Reads from page 0 use the short column-to-column delay of 4 cycles, and reads from any other page use the programmable long delay.

The request is checked before anything is issued. A bad request raises an error flag and sends no command. Completion is signalled by a one-cycle done pulse.

States: `ST_IDLE` (waits for start), `ST_PREA` (precharge-all offered), `ST_MR_ON` (MPR-enable write offered), `ST_READ` (read burst), `ST_MR_OFF` (MPR-disable write offered).

Transitions:
- `ST_IDLE` to `ST_PREA` on a valid start.
- `ST_PREA` to `ST_MR_ON` on accept.
- `ST_MR_ON` to `ST_READ` on accept.
- `ST_READ` to `ST_MR_OFF` on acceptance of the final read. Earlier reads stay in `ST_READ`.
- `ST_MR_OFF` to `ST_IDLE` on accept.
- An invalid start leaves the block in `ST_IDLE` with the error flag set.

Top module: `mpr_readout_seq`

## Requirements
- R1: An accepted request emits exactly these commands, in this order: precharge-all (code 1), a mode write (code 2) enabling MPR, count_i reads (code 3), and a mode write (code 2) disabling MPR. Every command carries the rank sampled at start. No other command appears, and cmd_valid_o then stays low.
- R2: The precharge-all has address 0, cmd_mr_o 0 and an idle count equal to trp_i as sampled at start.
- R3: Both mode writes carry an idle count equal to the larger of the TMOD and TMRD parameters (24 with the defaults).
- R4: A mode write has cmd_mr_o = 3. Its address has bit 2 = MPR enable (1 on the first write, 0 on the second), bits 1:0 = the page, bits 12:11 = the read format, and all other bits 0.
- R5: Each read has an idle count of 4 when the page is 0, and tccd_l_i (sampled at start) for pages 1, 2 and 3.
- R6: Read k (counting from 0) has address bits 1:0 = k mod 4 and all other bits 0, including bit 10, so no read carries auto-precharge. Its cmd_mr_o is 0.
- R7: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o stays high and every command field stays unchanged on the next cycle.
- R8: done_o is high for exactly the one cycle after the final mode write is accepted. busy_o is high from the cycle after an accepted start until that point.
- R9: A start with read format 3 or a read count of 0 sets err_o on the next cycle, issues no command and leaves busy_o low. err_o stays set until the next start and is cleared by a valid start.
- R10: A start pulse while busy_o is high is ignored. The running sequence keeps the fields it latched, whatever values the request inputs then carry.
- R11: After reset, cmd_valid_o, busy_o, done_o and err_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| rank_i | input | RANK_W | Target rank |
| page_i | input | 2 | MPR page |
| format_i | input | 2 | MPR read format (0 to 2 valid) |
| count_i | input | CNT_W | Number of reads (at least 1) |
| tccd_l_i | input | IDLE_W | Long column-to-column delay in cycles |
| trp_i | input | IDLE_W | Precharge period in cycles |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Executor accepts the command |
| cmd_code_o | output | 3 | 0 none, 1 precharge-all, 2 mode write, 3 read |
| cmd_rank_o | output | RANK_W | Rank of the command |
| cmd_mr_o | output | 2 | Mode-register select (3 for mode writes) |
| cmd_addr_o | output | ADDR_W | Address / mode-register image |
| cmd_idle_o | output | IDLE_W | Idle cycles the executor must insert after this command |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request was rejected |

## Verification
If the state register is corrupted, it shows at the next handshake: the command code or the mode-register image in the captured stream is out of order, or a command is missing. A wrong read counter shows as a wrong location in a read address, or as too many or too few reads before the disable write. In every case it also moves the done pulse away from the cycle right after the final accept. Wrong spacing values show on the idle field of the very command they belong to. A faulty parameter check shows one cycle after start, as a command appearing while err_o is high, or as an error on a good request.

// File: rtl/mpr_seq_pkg.sv
package mpr_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PREA = 3'd1,
        CMD_MRS  = 3'd2,
        CMD_RD   = 3'd3
    } cmd_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREA,
        ST_MR_ON,
        ST_READ,
        ST_MR_OFF
    } seq_state_e;

    localparam logic [1:0] MR_SEL_MPR = 2'd3;
    localparam logic [1:0] FMT_LIMIT  = 2'd2;

endpackage

// File: rtl/mpr_req_check.sv
module mpr_req_check #(
    parameter int CNT_W = 8
) (
    input  logic [1:0]       format_i,
    input  logic [1:0]       page_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             ok_o
);
    import mpr_seq_pkg::*;

    logic fmt_ok, page_ok, cnt_ok;

    always_comb begin
        fmt_ok  = (format_i <= FMT_LIMIT);
        page_ok = (page_i <= 2'd3);
        cnt_ok  = (count_i != '0);
        ok_o    = fmt_ok && page_ok && cnt_ok;
    end
endmodule

// File: rtl/mpr_read_ctr.sv
module mpr_read_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] total_i,
    output logic [CNT_W-1:0] idx_o,
    output logic             last_o
);
    logic [CNT_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            idx_q <= '0;
        end else if (step_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == total_i - 1'b1);
endmodule

// File: rtl/mpr_readout_seq.sv
module mpr_readout_seq
    import mpr_seq_pkg::*;
#(
    parameter int RANK_W = 2,
    parameter int ADDR_W = 14,
    parameter int IDLE_W = 8,
    parameter int CNT_W  = 8,
    parameter int TMOD   = 24,
    parameter int TMRD   = 8,
    parameter int TCCD_S = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RANK_W-1:0] rank_i,
    input  logic [1:0]        page_i,
    input  logic [1:0]        format_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [IDLE_W-1:0] tccd_l_i,
    input  logic [IDLE_W-1:0] trp_i,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [2:0]        cmd_code_o,
    output logic [RANK_W-1:0] cmd_rank_o,
    output logic [1:0]        cmd_mr_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [IDLE_W-1:0] cmd_idle_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int               MRS_GAP   = (TMOD > TMRD) ? TMOD : TMRD;
    localparam logic [IDLE_W-1:0] MRS_IDLE = IDLE_W'(MRS_GAP);
    localparam logic [IDLE_W-1:0] SHORT_RD = IDLE_W'(TCCD_S);

    seq_state_e        state_q, state_d;
    logic [RANK_W-1:0] rank_q;
    logic [1:0]        page_q, fmt_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDLE_W-1:0] tccdl_q, trp_q;
    logic              done_q, err_q;
    logic              req_ok, accept, take_start;
    logic [CNT_W-1:0]  rd_idx;
    logic              rd_last;
    logic [IDLE_W-1:0] rd_gap;

    mpr_req_check #(.CNT_W(CNT_W)) u_check (
        .format_i (format_i),
        .page_i   (page_i),
        .count_i  (count_i),
        .ok_o     (req_ok)
    );

    assign accept     = cmd_valid_o && cmd_ready_i;
    assign take_start = (state_q == ST_IDLE) && start_i;

    mpr_read_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q == ST_MR_ON),
        .step_i  ((state_q == ST_READ) && accept),
        .total_i (cnt_q),
        .idx_o   (rd_idx),
        .last_o  (rd_last)
    );

    // Mode write image: enable bit 2, page bits 1:0, read format bits 12:11
    function automatic logic [ADDR_W-1:0] mr3_image(input logic en);
        logic [ADDR_W-1:0] img;
        img        = '0;
        img[1:0]   = page_q;
        img[2]     = en;
        img[12:11] = fmt_q;
        return img;
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i && req_ok) state_d = ST_PREA;
            ST_PREA:   if (accept) state_d = ST_MR_ON;
            ST_MR_ON:  if (accept) state_d = ST_READ;
            ST_READ:   if (accept && rd_last) state_d = ST_MR_OFF;
            ST_MR_OFF: if (accept) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rank_q  <= '0;
            page_q  <= '0;
            fmt_q   <= '0;
            cnt_q   <= '0;
            tccdl_q <= '0;
            trp_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_MR_OFF) && accept;
            if (take_start) begin
                rank_q  <= rank_i;
                page_q  <= page_i;
                fmt_q   <= format_i;
                cnt_q   <= count_i;
                tccdl_q <= tccd_l_i;
                trp_q   <= trp_i;
                err_q   <= !req_ok;
            end
        end
    end

    assign rd_gap = (page_q == 2'd0) ? SHORT_RD : tccdl_q;

    always_comb begin
        cmd_valid_o = 1'b0;
        cmd_code_o  = CMD_NOP;
        cmd_mr_o    = 2'd0;
        cmd_addr_o  = '0;
        cmd_idle_o  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PREA: begin
                cmd_valid_o = 1'b1;
                cmd_code_o  = CMD_PREA;
                cmd_idle_o  = trp_q;
            end
            ST_MR_ON: begin
                cmd_valid_o = 1'b1;
                cmd_code_o  = CMD_MRS;
                cmd_mr_o    = MR_SEL_MPR;
                cmd_addr_o  = mr3_image(1'b1);
                cmd_idle_o  = MRS_IDLE;
            end
            ST_READ: begin
                cmd_valid_o     = 1'b1;
                cmd_code_o      = CMD_RD;
                cmd_addr_o[1:0] = rd_idx[1:0];
                cmd_idle_o      = rd_gap;
            end
            ST_MR_OFF: begin
                cmd_valid_o = 1'b1;
                cmd_code_o  = CMD_MRS;
                cmd_mr_o    = MR_SEL_MPR;
                cmd_addr_o  = mr3_image(1'b0);
                cmd_idle_o  = MRS_IDLE;
            end
            default: ;
        endcase
    end

    assign cmd_rank_o = rank_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
    assign err_o      = err_q;
endmodule

// File: rtl/mpr_readout_seq_chk.sv
module mpr_readout_seq_chk #(
    parameter int RANK_W = 2,
    parameter int ADDR_W = 14,
    parameter int IDLE_W = 8,
    parameter int TMOD   = 24,
    parameter int TMRD   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        code,
    input logic [RANK_W-1:0] rank,
    input logic [ADDR_W-1:0] addr,
    input logic [IDLE_W-1:0] idle,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [1:0]        page_q
);
    localparam int GAP = (TMOD > TMRD) ? TMOD : TMRD;

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(code) && $stable(addr)
                                    && $stable(idle) && $stable(rank));

    a_r1_starts_with_prea: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> code == 3'd1);

    a_r3_mode_gap: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && code == 3'd2 |-> idle == IDLE_W'(GAP));

    a_r6_no_autopre: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && code == 3'd3 |-> !addr[10]);

    a_r5_page0_gap: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && code == 3'd3 && page_q == 2'd0 |-> idle == IDLE_W'(4));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !cmd_valid && !busy);
endmodule

bind mpr_readout_seq mpr_readout_seq_chk #(
    .RANK_W(RANK_W), .ADDR_W(ADDR_W), .IDLE_W(IDLE_W), .TMOD(TMOD), .TMRD(TMRD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid_o),
    .cmd_ready (cmd_ready_i),
    .code      (cmd_code_o),
    .rank      (cmd_rank_o),
    .addr      (cmd_addr_o),
    .idle      (cmd_idle_o),
    .busy      (busy_o),
    .done      (done_o),
    .err       (err_o),
    .page_q    (page_q)
);

// File: tb/mpr_readout_seq_test.sv
module mpr_readout_seq_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] rank_i = '0;
    logic [1:0] page_i = '0;
    logic [1:0] format_i = '0;
    logic [7:0] count_i = '0;
    logic [7:0] tccd_l_i = '0;
    logic [7:0] trp_i = '0;
    logic       cmd_ready_i = 1'b0;
    logic       cmd_valid_o, busy_o, done_o, err_o;
    logic [2:0] cmd_code_o;
    logic [1:0] cmd_rank_o, cmd_mr_o;
    logic [13:0] cmd_addr_o;
    logic [7:0] cmd_idle_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    mpr_readout_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rank_i(rank_i),
        .page_i(page_i), .format_i(format_i), .count_i(count_i),
        .tccd_l_i(tccd_l_i), .trp_i(trp_i), .cmd_valid_o(cmd_valid_o),
        .cmd_ready_i(cmd_ready_i), .cmd_code_o(cmd_code_o), .cmd_rank_o(cmd_rank_o),
        .cmd_mr_o(cmd_mr_o), .cmd_addr_o(cmd_addr_o), .cmd_idle_o(cmd_idle_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [13:0] img(input logic en, input logic [1:0] pg, input logic [1:0] fm);
        logic [13:0] a = '0;
        a[1:0] = pg; a[2] = en; a[12:11] = fm;
        return a;
    endfunction

    task automatic test_reset();
        @(negedge clk);
        chk(cmd_valid_o == 0, "R11 valid", 32'(cmd_valid_o), 0);
        chk(busy_o == 0, "R11 busy", 32'(busy_o), 0);
        chk(done_o == 0, "R11 done", 32'(done_o), 0);
        chk(err_o == 0, "R11 err", 32'(err_o), 0);
    endtask

    task automatic run_seq(input logic [1:0] rk, input logic [1:0] pg, input logic [1:0] fm,
                           input logic [7:0] cnt, input logic [7:0] tl, input logic [7:0] tp,
                           input bit stall, input bit poke);
        int total, idx, cyc;
        logic [2:0] e_code; logic [1:0] e_mr; logic [13:0] e_addr; logic [7:0] e_idle;
        rank_i = rk; page_i = pg; format_i = fm; count_i = cnt; tccd_l_i = tl; trp_i = tp;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1, "R8 busy after start", 32'(busy_o), 1);
        chk(err_o == 0, "R9 err cleared by valid start", 32'(err_o), 0);
        total = int'(cnt) + 3; idx = 0; cyc = 0;
        while (idx < total && cyc < 5000) begin
            if (poke && idx == 2) begin
                start_i = 1'b1; page_i = ~pg; format_i = 2'd0; count_i = 8'd1;
                tccd_l_i = 8'd99; trp_i = 8'd77; rank_i = ~rk;
            end else begin
                start_i = 1'b0;
            end
            if (!cmd_valid_o) begin
                chk(0, "R1 command missing", 32'(idx), 32'(total));
                idx = total;
            end else if (stall && (cyc % 3 == 0)) begin
                cmd_ready_i = 1'b0;
            end else begin
                cmd_ready_i = 1'b1;
                if (idx == 0) begin
                    e_code = 3'd1; e_mr = 2'd0; e_addr = '0; e_idle = tp;
                end else if (idx == 1) begin
                    e_code = 3'd2; e_mr = 2'd3; e_addr = img(1'b1, pg, fm); e_idle = 8'd24;
                end else if (idx == total - 1) begin
                    e_code = 3'd2; e_mr = 2'd3; e_addr = img(1'b0, pg, fm); e_idle = 8'd24;
                end else begin
                    e_code = 3'd3; e_mr = 2'd0; e_addr = 14'((idx - 2) % 4);
                    e_idle = (pg == 2'd0) ? 8'd4 : tl;
                end
                chk(cmd_code_o == e_code, poke ? "R10 code" : "R1 code", 32'(cmd_code_o), 32'(e_code));
                chk(cmd_rank_o == rk, poke ? "R10 rank" : "R1 rank", 32'(cmd_rank_o), 32'(rk));
                chk(cmd_mr_o == e_mr, "R4 mr select", 32'(cmd_mr_o), 32'(e_mr));
                chk(cmd_addr_o == e_addr, e_code == 3'd3 ? "R6 read addr" : "R4 addr", 32'(cmd_addr_o), 32'(e_addr));
                chk(cmd_idle_o == e_idle, e_code == 3'd1 ? "R2 idle" : (e_code == 3'd2 ? "R3 idle" : "R5 idle"),
                    32'(cmd_idle_o), 32'(e_idle));
                idx++;
            end
            cyc++;
            @(negedge clk);
        end
        cmd_ready_i = 1'b0; start_i = 1'b0;
        chk(done_o == 1, "R8 done after last accept", 32'(done_o), 1);
        chk(cmd_valid_o == 0, "R1 no extra command", 32'(cmd_valid_o), 0);
        chk(busy_o == 0, "R8 busy cleared", 32'(busy_o), 0);
        @(negedge clk);
        chk(done_o == 0, "R8 done one cycle", 32'(done_o), 0);
    endtask

    task automatic err_case(input logic [1:0] fm, input logic [7:0] cnt);
        format_i = fm; count_i = cnt; page_i = 2'd1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(err_o == 1, "R9 err set and held", 32'(err_o), 1);
            chk(cmd_valid_o == 0, "R9 no command", 32'(cmd_valid_o), 0);
            chk(busy_o == 0, "R9 not busy", 32'(busy_o), 0);
            @(negedge clk);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_seq(2'd1, 2'd0, 2'd0, 8'd4, 8'd6, 8'd11, 1'b0, 1'b0);
        run_seq(2'd2, 2'd2, 2'd2, 8'd5, 8'd7, 8'd13, 1'b1, 1'b0);
        run_seq(2'd3, 2'd1, 2'd1, 8'd1, 8'd9, 8'd14, 1'b0, 1'b0);
        run_seq(2'd0, 2'd3, 2'd2, 8'd6, 8'd8, 8'd5, 1'b1, 1'b1);
        err_case(2'd3, 8'd4);
        run_seq(2'd1, 2'd0, 2'd1, 8'd3, 8'd6, 8'd2, 1'b0, 1'b0);
        err_case(2'd0, 8'd0);
        run_seq(2'd2, 2'd2, 2'd0, 8'd255, 8'd5, 8'd3, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule